// File: doc/BRIEF.md
# SPI/QPI Flash Instruction Front End

This block sits at the device end of a serial flash link and turns the first byte of each chip-select frame into a command opcode for downstream logic. It runs on a fast local clock and oversamples the serial clock, chip select and the four I/O lines through synchronizers. It reacts only to rising edges of the serial clock, so the clock may idle low or high between frames.

The block holds a persistent protocol mode. In single-line mode an opcode takes eight serial clocks on I/O line 0. In quad mode it takes two serial clocks on all four lines. Two in-band opcodes switch the mode, and each switch takes effect when chip select is released. The completed opcode leaves the block on a valid/ready stream with a single holding register. While `op_valid` is high and `op_ready` is low, `op_data` holds its value. If a new opcode completes while one is still waiting, the new one is dropped.

After the opcode phase, downstream logic can ask the block to drive the I/O lines. The block enables the lines that the current mode uses for device output.

Top module: `spi_qpi_front`

## Requirements
- R1: In single-line mode (`qpi_mode`=0) an opcode is formed from `io_in[0]` on 8 consecutive rising `sck` edges while `cs_n` is low, most significant bit first, and then appears on `op_data` with `op_valid` high.
- R2: In quad mode (`qpi_mode`=1) an opcode is formed in 2 rising `sck` edges. The first edge supplies bits [7:4] and the second supplies bits [3:0], with `io_in[3]` as the most significant bit of each nibble.
- R3: A completed 0x35 in single-line mode switches to quad mode, and a completed 0xF5 in quad mode switches back. 0x35 in quad mode, 0xF5 in single-line mode and all other opcodes leave the mode unchanged. The mode never changes while `cs_n` is still low; the switch is applied when `cs_n` rises.
- R4: Raising `cs_n` before an opcode is complete discards the partial bits. No opcode is presented, the mode is kept, and the next frame starts counting from zero.
- R5: Once the opcode of a frame is complete, any further `sck` edges in the same frame are ignored. They produce no opcode and cause no mode change.
- R6: While `op_valid` is high and `op_ready` is low, `op_valid` stays high and `op_data` does not change. An opcode that completes in that state is discarded from the stream, but it still takes part in mode switching. A handshake (`op_valid` and `op_ready` both high) clears `op_valid`.
- R7: `rst_n` low clears `op_valid` and selects single-line mode. A one-clock `sw_rst` pulse selects single-line mode and cancels any pending switch.
- R8: Frames work with `sck` idling low or idling high, because only rising edges are sampled.
- R9: `io_oe` is 0 while the block is deselected and before the opcode of the frame is complete. After that, with `drv_en` high, quad mode drives all four lines with `drv_data`. Single-line mode drives only line 1, which carries `drv_data[0]`; `io_oe` is then 4'b0010.
- R10: `qpi_mode` reports the active mode at all times. It is 1 for quad mode and 0 for single-line mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| io_in | input | 4 | Input values of I/O lines 3..0 |
| io_out | output | 4 | Output values for I/O lines 3..0 |
| io_oe | output | 4 | Per-line output enable |
| op_valid | output | 1 | Opcode stream valid |
| op_ready | input | 1 | Opcode stream ready from downstream |
| op_data | output | 8 | Received opcode |
| drv_en | input | 1 | Downstream request to drive the I/O lines |
| drv_data | input | 4 | Data to drive when enabled |
| sw_rst | input | 1 | One-clock software reset of the mode |
| qpi_mode | output | 1 | 1 in quad mode, 0 in single-line mode |

## Verification
The bench targets the timing of mode switches. A design that switched as soon as the opcode completed would show `qpi_mode` changing with chip select still low. A design that ignored which mode an opcode arrived in would react to 0x35 in quad mode or 0xF5 in single-line mode. Aborted frames, trailing clocks after an opcode and a stalled output stream are each checked, because a counter that is not cleared or a holding register that is overwritten would produce a wrong or extra opcode. Output enables are checked before and after the opcode in both modes, where a careless design would drive the lines during the command phase or drive the wrong set of lines.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int OP_W = 8;
  localparam logic [OP_W-1:0] OPC_GO_QUAD  = 8'h35;
  localparam logic [OP_W-1:0] OPC_GO_SINGLE = 8'hF5;
  typedef enum logic {MODE_SINGLE = 1'b0, MODE_QUAD = 1'b1} link_mode_e;
endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fe_shift.sv
module fe_shift
  import fe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck_rise,
  input  logic            cs_low,
  input  logic            quad,
  input  logic [3:0]      io,
  output logic            done_p,
  output logic            hdr_done,
  output logic [OP_W-1:0] op_byte
);
  localparam int CW = $clog2(OP_W);
  localparam logic [CW-1:0] LAST_SINGLE = CW'(OP_W - 1);
  localparam logic [CW-1:0] LAST_QUAD   = CW'(OP_W / 4 - 1);

  logic [CW-1:0]   cnt;
  logic [OP_W-1:0] shreg;
  logic [CW-1:0]   last;
  logic            take;

  assign last = quad ? LAST_QUAD : LAST_SINGLE;
  assign take = cs_low && sck_rise && !hdr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      shreg    <= '0;
      hdr_done <= 1'b0;
      done_p   <= 1'b0;
    end else begin
      done_p <= take && (cnt == last);
      if (!cs_low) begin
        cnt      <= '0;
        hdr_done <= 1'b0;
      end else if (take) begin
        shreg <= quad ? {shreg[OP_W-5:0], io} : {shreg[OP_W-2:0], io[0]};
        if (cnt == last) begin
          cnt      <= '0;
          hdr_done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign op_byte = shreg;
endmodule

// File: rtl/fe_mode.sv
module fe_mode
  import fe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done_p,
  input  logic [OP_W-1:0] op_byte,
  input  logic            cs_rise,
  input  logic            sw_rst,
  output link_mode_e      mode
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_SINGLE;
      pend <= 1'b0;
    end else if (sw_rst) begin
      mode <= MODE_SINGLE;
      pend <= 1'b0;
    end else begin
      if (done_p)
        pend <= (mode == MODE_SINGLE && op_byte == OPC_GO_QUAD) ||
                (mode == MODE_QUAD && op_byte == OPC_GO_SINGLE);
      if (cs_rise) begin
        pend <= 1'b0;
        if (pend) mode <= (mode == MODE_SINGLE) ? MODE_QUAD : MODE_SINGLE;
      end
    end
  end
endmodule

// File: rtl/spi_qpi_front.sv
module spi_qpi_front
  import fe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck,
  input  logic            cs_n,
  input  logic [3:0]      io_in,
  output logic [3:0]      io_out,
  output logic [3:0]      io_oe,
  output logic            op_valid,
  input  logic            op_ready,
  output logic [OP_W-1:0] op_data,
  input  logic            drv_en,
  input  logic [3:0]      drv_data,
  input  logic            sw_rst,
  output logic            qpi_mode
);
  localparam int SW = 6;

  logic [SW-1:0]   raw_in, syn;
  logic            sck_s, cs_n_s, sck_d, cs_low_d;
  logic [3:0]      io_s;
  logic            sck_rise, cs_low, cs_rise;
  logic            done_p, hdr_done;
  logic [OP_W-1:0] op_byte;
  link_mode_e      mode;

  assign raw_in = {sck, cs_n, io_in};

  fe_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(6'b01_0000)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  assign sck_s  = syn[5];
  assign cs_n_s = syn[4];
  assign io_s   = syn[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      cs_low_d <= 1'b0;
    end else begin
      sck_d    <= sck_s;
      cs_low_d <= !cs_n_s;
    end
  end

  assign cs_low   = !cs_n_s;
  assign sck_rise = sck_s && !sck_d;
  assign cs_rise  = cs_low_d && !cs_low;

  fe_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .cs_low(cs_low),
    .quad(mode == MODE_QUAD), .io(io_s), .done_p(done_p),
    .hdr_done(hdr_done), .op_byte(op_byte)
  );

  fe_mode u_mode (
    .clk(clk), .rst_n(rst_n), .done_p(done_p), .op_byte(op_byte),
    .cs_rise(cs_rise), .sw_rst(sw_rst), .mode(mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      op_data  <= '0;
    end else if (!op_valid || op_ready) begin
      op_valid <= done_p;
      if (done_p) op_data <= op_byte;
    end
  end

  assign qpi_mode = (mode == MODE_QUAD);

  always_comb begin
    io_oe  = 4'b0000;
    io_out = 4'b0000;
    if (cs_low && hdr_done && drv_en) begin
      if (qpi_mode) begin
        io_oe  = 4'b1111;
        io_out = drv_data;
      end else begin
        io_oe  = 4'b0010;
        io_out = {2'b00, drv_data[0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/fe_chk.sv
module fe_chk
  import fe_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            sw_rst,
  input logic            op_valid,
  input logic            op_ready,
  input logic [OP_W-1:0] op_data,
  input logic            qpi_mode,
  input logic [3:0]      io_oe,
  input logic            cs_low,
  input logic            cs_rise
);
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_data))); // R6

  AST_MODE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(qpi_mode) |-> ($past(cs_rise) || $past(sw_rst))); // R3

  AST_SWRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> !qpi_mode); // R7

  AST_SINGLE_DRIVES_LINE1: assert property (@(posedge clk) disable iff (!rst_n)
    !qpi_mode |-> (io_oe[3:2] == 2'b00 && io_oe[0] == 1'b0)); // R9

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low |-> (io_oe == 4'b0000)); // R9
endmodule

bind spi_qpi_front fe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .op_valid(op_valid),
  .op_ready(op_ready), .op_data(op_data), .qpi_mode(qpi_mode),
  .io_oe(io_oe), .cs_low(cs_low), .cs_rise(cs_rise)
);

// File: tb/tb_spi_qpi_front.sv
module tb_spi_qpi_front;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0;
  logic       cs_n = 1'b1;
  logic [3:0] io_in = 4'h0;
  logic [3:0] io_out, io_oe;
  logic       op_valid;
  logic       op_ready = 1'b0;
  logic [7:0] op_data;
  logic       drv_en = 1'b0;
  logic [3:0] drv_data = 4'h0;
  logic       sw_rst = 1'b0;
  logic       qpi_mode;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  spi_qpi_front dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .op_valid(op_valid), .op_ready(op_ready),
    .op_data(op_data), .drv_en(drv_en), .drv_data(drv_data),
    .sw_rst(sw_rst), .qpi_mode(qpi_mode)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_begin();
    @(negedge clk); cs_n = 1'b0;
    nclk(4);
  endtask

  task automatic frame_end(input logic idle);
    @(negedge clk); sck = idle;
    nclk(2);
    cs_n = 1'b1;
    nclk(10);
  endtask

  task automatic put(input logic [3:0] v);
    @(negedge clk); sck = 1'b0; io_in = v;
    nclk(4);
    sck = 1'b1;
    nclk(4);
  endtask

  task automatic spi_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) put({3'b000, v[7-i]});
  endtask

  task automatic qpi_nibs(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) put(i == 0 ? v[7:4] : v[3:0]);
  endtask

  task automatic accept();
    @(negedge clk); op_ready = 1'b1;
    @(negedge clk); op_ready = 1'b0;
    nclk(1);
  endtask

  task automatic send_spi(input logic [7:0] v, input logic idle);
    frame_begin(); spi_bits(v, 8); frame_end(idle);
  endtask

  task automatic send_qpi(input logic [7:0] v);
    frame_begin(); qpi_nibs(v, 2); frame_end(1'b0);
  endtask

  task automatic t_reset();
    nclk(1);
    check(op_valid == 1'b0, "R7 reset valid", op_valid, 0);
    check(qpi_mode == 1'b0, "R7 reset mode", qpi_mode, 0);
    check(io_oe == 4'h0, "R9 reset oe", io_oe, 0);
  endtask

  task automatic t_spi_idle_low();
    send_spi(8'h9F, 1'b0);
    check(op_valid == 1'b1, "R1 valid", op_valid, 1);
    check(op_data == 8'h9F, "R1 data", op_data, 8'h9F);
    accept();
    check(op_valid == 1'b0, "R6 handshake clears", op_valid, 0);
  endtask

  task automatic t_spi_idle_high();
    @(negedge clk); sck = 1'b1;
    nclk(4);
    send_spi(8'h03, 1'b1);
    check(op_data == 8'h03 && op_valid, "R8 idle-high frame", op_data, 8'h03);
    accept();
    @(negedge clk); sck = 1'b0;
    nclk(4);
  endtask

  task automatic t_partial_spi();
    frame_begin(); spi_bits(8'h35, 7); frame_end(1'b0);
    check(op_valid == 1'b0, "R4 partial gives no opcode", op_valid, 0);
    check(qpi_mode == 1'b0, "R4 partial keeps mode", qpi_mode, 0);
    send_spi(8'h6B, 1'b0);
    check(op_data == 8'h6B, "R4 next frame aligned", op_data, 8'h6B);
    accept();
  endtask

  task automatic t_single_exit_ignored();
    send_spi(8'hF5, 1'b0);
    check(qpi_mode == 1'b0, "R3 F5 in single mode ignored", qpi_mode, 0);
    check(op_data == 8'hF5, "R1 F5 presented", op_data, 8'hF5);
    accept();
  endtask

  task automatic t_trailing();
    frame_begin(); spi_bits(8'hA5, 8); spi_bits(8'h35, 8); frame_end(1'b0);
    check(op_data == 8'hA5, "R5 first byte kept", op_data, 8'hA5);
    check(qpi_mode == 1'b0, "R5 trailing bits no switch", qpi_mode, 0);
    accept();
    check(op_valid == 1'b0, "R5 no second opcode", op_valid, 0);
  endtask

  task automatic t_backpressure();
    send_spi(8'h11, 1'b0);
    send_spi(8'h22, 1'b0);
    check(op_valid == 1'b1, "R6 stalled valid held", op_valid, 1);
    check(op_data == 8'h11, "R6 stalled data held", op_data, 8'h11);
    accept();
    check(op_valid == 1'b0, "R6 dropped opcode absent", op_valid, 0);
  endtask

  task automatic t_drive(input logic quad);
    frame_begin();
    @(negedge clk); drv_en = 1'b1; drv_data = quad ? 4'hA : 4'h3;
    nclk(2);
    check(io_oe == 4'h0, "R9 no drive before opcode", io_oe, 0);
    if (quad) qpi_nibs(8'h0B, 2); else spi_bits(8'h0B, 8);
    nclk(6);
    check(io_oe == (quad ? 4'hF : 4'h2), "R9 oe after opcode", io_oe,
          quad ? 4'hF : 4'h2);
    check(io_out == (quad ? 4'hA : 4'h2), "R9 driven value", io_out,
          quad ? 4'hA : 4'h2);
    frame_end(1'b0);
    check(io_oe == 4'h0, "R9 released after deselect", io_oe, 0);
    @(negedge clk); drv_en = 1'b0;
    accept();
  endtask

  task automatic t_enter_quad();
    frame_begin(); spi_bits(8'h35, 8);
    nclk(8);
    check(qpi_mode == 1'b0, "R3 no switch while selected", qpi_mode, 0);
    frame_end(1'b0);
    check(qpi_mode == 1'b1, "R3 switch to quad", qpi_mode, 1);
    check(qpi_mode == 1'b1, "R10 mode output quad", qpi_mode, 1);
    accept();
  endtask

  task automatic t_quad_op();
    send_qpi(8'hEB);
    check(op_data == 8'hEB && op_valid, "R2 quad opcode", op_data, 8'hEB);
    check(qpi_mode == 1'b1, "R3 other opcode keeps quad", qpi_mode, 1);
    accept();
    send_qpi(8'h35);
    check(qpi_mode == 1'b1, "R3 35 in quad ignored", qpi_mode, 1);
    accept();
  endtask

  task automatic t_abort_quad();
    frame_begin(); qpi_nibs(8'hF5, 1); frame_end(1'b0);
    check(op_valid == 1'b0, "R4 quad abort no opcode", op_valid, 0);
    check(qpi_mode == 1'b1, "R4 quad abort keeps mode", qpi_mode, 1);
  endtask

  task automatic t_exit_quad();
    send_qpi(8'hF5);
    check(op_data == 8'hF5, "R2 exit opcode", op_data, 8'hF5);
    check(qpi_mode == 1'b0, "R3 back to single", qpi_mode, 0);
    accept();
  endtask

  task automatic t_sw_reset();
    send_spi(8'h35, 1'b0); accept();
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); sw_rst = 1'b0;
    nclk(1);
    check(qpi_mode == 1'b0, "R7 software reset", qpi_mode, 0);
  endtask

  task automatic t_hw_reset();
    send_spi(8'h35, 1'b0); accept();
    send_qpi(8'h66);
    @(negedge clk); rst_n = 1'b0;
    nclk(2);
    rst_n = 1'b1;
    nclk(2);
    check(qpi_mode == 1'b0, "R7 hardware reset mode", qpi_mode, 0);
    check(op_valid == 1'b0, "R7 hardware reset valid", op_valid, 0);
  endtask

  initial begin
    nclk(3);
    rst_n = 1'b1;
    nclk(3);
    t_reset();
    t_spi_idle_low();
    t_spi_idle_high();
    t_partial_spi();
    t_single_exit_ignored();
    t_trailing();
    t_backpressure();
    t_drive(1'b0);
    t_enter_quad();
    t_quad_op();
    t_drive(1'b1);
    t_abort_quad();
    t_exit_quad();
    t_sw_reset();
    t_hw_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule